// File: doc/BRIEF.md
# Data-Processing ALU With Carry-Chain Opcodes

This block is the combinational arithmetic and logic stage of a 32-bit processor datapath. It takes a 4-bit operation code, a first operand, an already prepared second operand (a shifted register value or a rotated immediate, chosen upstream) and the current flag state. It returns the 32-bit result, a destination write enable and the next negative, zero, carry and overflow flags.

The sixteen operations include plain and carry-propagating add and subtract, reverse subtract in which the second operand is the minuend, and four compare/test operations that update flags only. The subtract-with-carry forms use the inverted carry flag as a borrow. A set-flags input selects whether the computed flags are presented or the old flags pass through unchanged. The operand shifter, the immediate rotator, condition evaluation and the register file sit outside this block.

Top module: `dp_alu`

## Requirements
- R1: Logical opcodes give result = A AND B (0x0), A XOR B (0x1), A OR B (0xC), B (0xD), A AND NOT B (0xE), NOT B (0xF).
- R2: Arithmetic opcodes give result, modulo 2^32: A-B (0x2), B-A (0x3), A+B (0x4), A+B+C (0x5), A-B-(1-C) (0x6), B-A-(1-C) (0x7), where C is the `carry_in` port.
- R3: `dest_we` is 0 for opcodes 0x8 to 0xB and 1 for every other opcode.
- R4: With `set_flags` = 1, `n_out` equals result bit 31 and `z_out` is 1 exactly when the 32-bit result is zero.
- R5: With `set_flags` = 1, opcodes 0x4, 0x5 and 0xB set `c_out` to the unsigned carry out of bit 31.
- R6: With `set_flags` = 1, opcodes 0x2, 0x3, 0x6, 0x7 and 0xA set `c_out` to 1 when the unsigned subtraction needs no borrow and 0 when it does.
- R7: With `set_flags` = 1, opcodes 0x2 to 0x7, 0xA and 0xB set `v_out` to 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R8: With `set_flags` = 1, the logical opcodes (0x0, 0x1, 0x8, 0x9, 0xC to 0xF) set `c_out` to `shift_carry` and keep `v_out` equal to `v_in`.
- R9: With `set_flags` = 0, `n_out`, `z_out`, `c_out`, `v_out` equal `n_in`, `z_in`, `carry_in`, `v_in`.
- R10: Opcodes 0x8, 0x9, 0xA, 0xB drive `result` with A AND B, A XOR B, A-B and A+B respectively, so their flags follow those values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Prepared second operand |
| carry_in | input | 1 | Current carry flag |
| shift_carry | input | 1 | Carry produced by the operand shifter |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| v_in | input | 1 | Current overflow flag |
| set_flags | input | 1 | 1 applies the computed flags, 0 passes the old flags |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Destination write enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
The bound checker watches, on every input change, the write-enable pattern of the compare/test opcodes, the pass-through of all four flags when set-flags is low, the sign and zero flags against the result, the logical-class carry and overflow sources, and the carry of the plain add. The borrow convention of the subtract and reverse-subtract forms, the inverted-carry borrow of the carry opcodes, signed overflow in every arithmetic class and the exact result values are shown only by the bench sweep, which crosses every opcode with edge operands near zero, the sign boundary and all-ones, both carry values and both set-flags settings.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
   typedef enum logic [3:0] {
      OP_AND   = 4'h0, OP_XOR   = 4'h1, OP_SUB   = 4'h2, OP_RSUB  = 4'h3,
      OP_ADD   = 4'h4, OP_ADDC  = 4'h5, OP_SUBC  = 4'h6, OP_RSUBC = 4'h7,
      OP_TAND  = 4'h8, OP_TXOR  = 4'h9, OP_CSUB  = 4'hA, OP_CADD  = 4'hB,
      OP_OR    = 4'hC, OP_PASSB = 4'hD, OP_ANDN  = 4'hE, OP_NOTB  = 4'hF
   } dp_op_e;

   typedef enum logic [1:0] {
      FC_LOGIC = 2'd0,
      FC_ADD   = 2'd1,
      FC_SUB   = 2'd2,
      FC_RSUB  = 2'd3
   } flag_class_e;

   typedef enum logic [1:0] {
      CI_ZERO = 2'd0,
      CI_ONE  = 2'd1,
      CI_FLAG = 2'd2
   } cin_sel_e;
endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
   import dp_alu_pkg::*;
(
   input  logic [3:0]  op_code,
   output flag_class_e fclass,
   output logic        swap_ops,
   output logic        invert_y,
   output cin_sel_e    cin_sel,
   output logic        dest_we
);
   always_comb begin
      fclass   = FC_LOGIC;
      swap_ops = 1'b0;
      invert_y = 1'b0;
      cin_sel  = CI_ZERO;
      unique case (dp_op_e'(op_code))
         OP_ADD, OP_CADD: fclass = FC_ADD;
         OP_ADDC: begin
            fclass  = FC_ADD;
            cin_sel = CI_FLAG;
         end
         OP_SUB, OP_CSUB: begin
            fclass   = FC_SUB;
            invert_y = 1'b1;
            cin_sel  = CI_ONE;
         end
         OP_SUBC: begin
            fclass   = FC_SUB;
            invert_y = 1'b1;
            cin_sel  = CI_FLAG;
         end
         OP_RSUB: begin
            fclass   = FC_RSUB;
            swap_ops = 1'b1;
            invert_y = 1'b1;
            cin_sel  = CI_ONE;
         end
         OP_RSUBC: begin
            fclass   = FC_RSUB;
            swap_ops = 1'b1;
            invert_y = 1'b1;
            cin_sel  = CI_FLAG;
         end
         default: fclass = FC_LOGIC;
      endcase
      dest_we = (op_code[3:2] != 2'b10);
   end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_fast
         assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
      end
   endgenerate
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (op_code)
         4'h0, 4'h8: y = a & b;
         4'h1, 4'h9: y = a ^ b;
         4'hC:       y = a | b;
         4'hD:       y = b;
         4'hE:       y = a & ~b;
         4'hF:       y = ~b;
         default:    y = '0;
      endcase
   end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dp_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  flag_class_e      fclass,
   input  logic             set_flags,
   input  logic [WIDTH-1:0] res,
   input  logic             add_cout,
   input  logic             x_msb,
   input  logic             y_msb,
   input  logic             shift_carry,
   input  logic             n_in,
   input  logic             z_in,
   input  logic             c_in,
   input  logic             v_in,
   output logic             n_out,
   output logic             z_out,
   output logic             c_out,
   output logic             v_out
);
   localparam int MSB = WIDTH - 1;
   logic arith;
   logic ovf;

   assign arith = (fclass != FC_LOGIC);
   // Operand signs agree while the sum sign differs: signed overflow.
   assign ovf   = (x_msb == y_msb) && (res[MSB] != x_msb);

   always_comb begin
      if (set_flags) begin
         n_out = res[MSB];
         z_out = (res == '0);
         c_out = arith ? add_cout : shift_carry;
         v_out = arith ? ovf : v_in;
      end else begin
         n_out = n_in;
         z_out = z_in;
         c_out = c_in;
         v_out = v_in;
      end
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   input  logic             shift_carry,
   input  logic             n_in,
   input  logic             z_in,
   input  logic             v_in,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             dest_we,
   output logic             n_out,
   output logic             z_out,
   output logic             c_out,
   output logic             v_out
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dp_alu: WIDTH must be at least 2");
      end
   endgenerate

   flag_class_e      fclass;
   logic             swap_ops;
   logic             invert_y;
   cin_sel_e         cin_sel;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout;
   logic [WIDTH-1:0] logic_res;

   dp_alu_decode u_decode (
      .op_code  (op_code),
      .fclass   (fclass),
      .swap_ops (swap_ops),
      .invert_y (invert_y),
      .cin_sel  (cin_sel),
      .dest_we  (dest_we)
   );

   // Subtraction is x + ~y + cin; the borrow-in of the carry forms is !C,
   // which this form absorbs by feeding C straight in as cin.
   assign add_x = swap_ops ? opnd_b : opnd_a;
   assign add_y = invert_y ? ~(swap_ops ? opnd_a : opnd_b)
                           :  (swap_ops ? opnd_a : opnd_b);

   always_comb begin
      unique case (cin_sel)
         CI_ONE:  add_cin = 1'b1;
         CI_FLAG: add_cin = carry_in;
         default: add_cin = 1'b0;
      endcase
   end

   dp_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout)
   );

   dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op_code (op_code),
      .a       (opnd_a),
      .b       (opnd_b),
      .y       (logic_res)
   );

   assign result = (fclass == FC_LOGIC) ? logic_res : add_sum;

   dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .fclass      (fclass),
      .set_flags   (set_flags),
      .res         (result),
      .add_cout    (add_cout),
      .x_msb       (add_x[MSB]),
      .y_msb       (add_y[MSB]),
      .shift_carry (shift_carry),
      .n_in        (n_in),
      .z_in        (z_in),
      .c_in        (carry_in),
      .v_in        (v_in),
      .n_out       (n_out),
      .z_out       (z_out),
      .c_out       (c_out),
      .v_out       (v_out)
   );
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [3:0]       op_code,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             carry_in,
   input logic             shift_carry,
   input logic             n_in,
   input logic             z_in,
   input logic             v_in,
   input logic             set_flags,
   input logic [WIDTH-1:0] result,
   input logic             dest_we,
   input logic             n_out,
   input logic             z_out,
   input logic             c_out,
   input logic             v_out
);
   localparam int MSB = WIDTH - 1;
   logic           is_logical;
   logic [WIDTH:0] plain_sum;

   assign is_logical = (op_code[2:1] == 2'b00) || (op_code[3:2] == 2'b11);
   assign plain_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};

   always_comb begin
      // R3: compare/test opcodes never write the destination
      a_r3_dest_we: assert (dest_we == (op_code[3:2] != 2'b10));
      if (!set_flags) begin
         // R9: flags pass through when not updating
         a_r9_flags_hold: assert (n_out == n_in && z_out == z_in &&
                                  c_out == carry_in && v_out == v_in);
      end else begin
         // R4: sign and zero follow the result
         a_r4_nz: assert (n_out == result[MSB] && z_out == (result == '0));
         if (is_logical) begin
            // R8: logical class carry from shifter, overflow kept
            a_r8_logic_cv: assert (c_out == shift_carry && v_out == v_in);
         end
         if (op_code == 4'h4) begin
            // R5: plain add carry is the unsigned carry out
            a_r5_add_carry: assert (c_out == plain_sum[WIDTH]);
         end
      end
   end
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_code     (op_code),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .carry_in    (carry_in),
   .shift_carry (shift_carry),
   .n_in        (n_in),
   .z_in        (z_in),
   .v_in        (v_in),
   .set_flags   (set_flags),
   .result      (result),
   .dest_we     (dest_we),
   .n_out       (n_out),
   .z_out       (z_out),
   .c_out       (c_out),
   .v_out       (v_out)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_code = 4'h0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        carry_in = 1'b0, shift_carry = 1'b0;
   logic        n_in = 1'b0, z_in = 1'b0, v_in = 1'b0, set_flags = 1'b0;
   logic [31:0] result;
   logic        dest_we, n_out, z_out, c_out, v_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   dp_alu u_dut (
      .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .carry_in(carry_in), .shift_carry(shift_carry),
      .n_in(n_in), .z_in(z_in), .v_in(v_in), .set_flags(set_flags),
      .result(result), .dest_we(dest_we),
      .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired: actual cycles %0d expected < 100000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s op=%h a=%h b=%h c=%0b sf=%0b: actual %h expected %h",
                  tag, op_code, opnd_a, opnd_b, carry_in, set_flags, act, exp);
      end
   endtask

   function automatic logic [31:0] pick(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'hFFFF_FFFF;
         5: return 32'h1234_5678;
         6: return 32'h8000_0001;
         default: return 32'hFFFF_FFFE;
      endcase
   endfunction

   task automatic run_vector();
      longint ua, ub, sa, sb, u, s, nb;
      logic [31:0] er;
      logic arith, ec, ev;
      string rtag, ctag;
      ua = longint'({32'h0, opnd_a});
      ub = longint'({32'h0, opnd_b});
      sa = longint'($signed(opnd_a));
      sb = longint'($signed(opnd_b));
      nb = carry_in ? 0 : 1;
      arith = 1'b1; u = 0; s = 0; ec = 1'b0;
      rtag = "R2"; ctag = "R6";
      case (op_code)
         4'h2, 4'hA: begin u = ua - ub;      s = sa - sb;      end
         4'h3:       begin u = ub - ua;      s = sb - sa;      end
         4'h4, 4'hB: begin u = ua + ub;      s = sa + sb;      ctag = "R5"; end
         4'h5:       begin u = ua + ub + (carry_in ? 1 : 0);
                           s = sa + sb + (carry_in ? 1 : 0); ctag = "R5"; end
         4'h6:       begin u = ua - ub - nb; s = sa - sb - nb; end
         4'h7:       begin u = ub - ua - nb; s = sb - sa - nb; end
         default: arith = 1'b0;
      endcase
      if (op_code >= 4'h8 && op_code <= 4'hB) rtag = "R10";
      if (arith) begin
         er = u[31:0];
         if (ctag == "R5") ec = u[32];
         else              ec = (u >= 0);
         ev = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end else begin
         rtag = (op_code >= 4'h8) && (op_code <= 4'hB) ? "R10" : "R1";
         case (op_code)
            4'h0, 4'h8: er = opnd_a & opnd_b;
            4'h1, 4'h9: er = opnd_a ^ opnd_b;
            4'hC:       er = opnd_a | opnd_b;
            4'hD:       er = opnd_b;
            4'hE:       er = opnd_a & ~opnd_b;
            default:    er = ~opnd_b;
         endcase
         ec = shift_carry;
         ev = v_in;
         ctag = "R8";
      end
      check(rtag, result, er);
      check("R3 dest_we", {31'b0, dest_we}, {31'b0, !(op_code >= 4'h8 && op_code <= 4'hB)});
      if (!set_flags) begin
         check("R9 flags held", {28'b0, n_out, z_out, c_out, v_out},
               {28'b0, n_in, z_in, carry_in, v_in});
      end else begin
         check("R4 N,Z", {30'b0, n_out, z_out}, {30'b0, er[31], er == 32'h0});
         check(ctag, {31'b0, c_out}, {31'b0, ec});
         check(arith ? "R7 V" : "R8 V", {31'b0, v_out}, {31'b0, ev});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // Reset state: all-zero inputs give a zero AND result with write enable
      #1;
      check("R1 reset zero", result, 32'h0);
      check("R3 reset we", {31'b0, dest_we}, 32'h1);
      for (int op = 0; op < 16; op++) begin
         for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  for (int sf = 0; sf < 2; sf++) begin
                     @(negedge clk);
                     op_code     = 4'(op);
                     opnd_a      = pick(ia);
                     opnd_b      = pick(ib);
                     carry_in    = ci[0];
                     set_flags   = sf[0];
                     shift_carry = ia[1] ^ ib[0];
                     n_in        = ia[0];
                     z_in        = ib[0] ^ ci[0];
                     v_in        = ib[1] ^ ci[0];
                     #1;
                     run_vector();
                  end
               end
            end
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule